// File: doc/BRIEF.md
# Reset-Time Serial ROM Boot Sequencer

This block runs once after hardware reset. It decides from an enable strap whether to configure the chip from an external serial EEPROM. When it is enabled, it drives a byte-level I2C master engine to fetch a list of register-write records from the ROM. It replays each record on a simple configuration write port, and it keeps the processor core in reset until the list has been consumed. When the strap is clear, the core is let go straight away with default settings and the I2C side stays silent.

The ROM image starts with a two-byte signature. Records follow it. Each record holds a 16-bit register address and then 32 bits of data, and both fields are sent most significant byte first. The address value 0xFFFF ends the list. A signature mismatch, or a NACK on any byte the block writes, stops the run and sets an error flag. The core is then released with defaults.

The bit-level I2C engine sits outside this block. The block hands the engine one command at a time and waits for that command's completion strobe before it issues the next.

Top module: `boot_sequencer`

## Requirements
- R1: `boot_strap` is captured on the first rising clock edge after `rst_n` goes high. Later changes to `boot_strap` have no effect on the run.
- R2: With the captured strap at 0, the block issues no I2C command. `seq_done` goes to 1, `core_hold` goes to 0 and `seq_err` stays 0, all visible after the second rising edge after reset release.
- R3: `core_hold` is 1 during reset and for as long as `seq_done` is 0. Once `seq_done` is 1, it stays 1 with `core_hold` at 0 until the next reset, and no configuration write appears while `core_hold` is 0.
- R4: With the strap at 1, the block issues commands in this order: START, WRITE {DEV_ADDR,0}, WRITE 0x00, WRITE 0x00, START, WRITE {DEV_ADDR,1}, then READs. The `i2c_cmd` codes are 0=START, 1=STOP, 2=WRITE and 3=READ.
- R5: The first two bytes read must equal PREAMBLE, with the first byte read as bits 15:8. On a mismatch, `seq_err` is set and no configuration write takes place.
- R6: After the signature, every group of six bytes is one record. Bytes 1 and 2 form `cfg_addr`, high byte first. Bytes 3 to 6 form `cfg_wdata`, MSB first. Each complete record gives exactly one one-cycle `cfg_we` pulse, and the pulses come in ROM order.
- R7: A record address of 0xFFFF ends the list with no configuration write and no error, and that record's data bytes are not fetched. An address whose high byte alone is 0xFF is an ordinary record.
- R8: Once reading has started, every READ carries `i2c_rd_nack`=0 except the final one. The run ends with one READ carrying `i2c_rd_nack`=1, then STOP, then `seq_done`.
- R9: A NACK reported on any WRITE makes the block issue STOP, set `seq_err` and finish with `seq_done`, with no READ issued.
- R10: `i2c_cmd_valid` is a one-cycle pulse. The next command is issued only after `i2c_done` has answered the current one.
- R11: After `seq_done` rises, no further I2C command or configuration write is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boot_strap | input | 1 | Sequencer enable strap |
| i2c_cmd_valid | output | 1 | One-cycle command request to the I2C engine |
| i2c_cmd | output | 2 | Command code: 0 START, 1 STOP, 2 WRITE, 3 READ |
| i2c_wbyte | output | 8 | Byte to send with WRITE |
| i2c_rd_nack | output | 1 | With READ: answer the byte with NACK |
| i2c_done | input | 1 | One-cycle completion strobe from the engine |
| i2c_nack | input | 1 | With `i2c_done` of a WRITE: the slave did not acknowledge |
| i2c_rbyte | input | 8 | With `i2c_done` of a READ: the byte received |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_addr | output | CFG_AW | Configuration register address |
| cfg_wdata | output | CFG_DW | Configuration write data |
| core_hold | output | 1 | 1 keeps the processor core in reset |
| seq_done | output | 1 | Sequence finished, whether completed or aborted |
| seq_err | output | 1 | Sequence aborted by a NACK or a bad signature |

## Verification
The strap is sampled one edge after reset release. The done-or-start decision shows one edge after that, so the bench checks both at the falling edges after those two rising edges. Every I2C command is answered with a random delay of zero to two cycles. `cfg_we` appears one edge after the `i2c_done` of a record's last data byte. `seq_done` rises one edge after the STOP completes. The bench therefore logs commands and writes at every falling edge and compares the full logs with a sequence computed from the ROM image only after `seq_done`, plus ten idle cycles in which nothing more may appear.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2c_op_e;

  localparam int BYTE_W  = 8;
  localparam int SIG_W   = 16;
endpackage

// File: rtl/bseq_strap_latch.sv
module bseq_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic cap_vld_o,
  output logic strap_o
);
  logic cap_vld_q, cap_vld_d;
  logic strap_q, strap_d;

  always_comb begin
    cap_vld_d = cap_vld_q;
    strap_d   = strap_q;
    if (!cap_vld_q) begin
      cap_vld_d = 1'b1;
      strap_d   = strap_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld_q <= 1'b0;
      strap_q   <= 1'b0;
    end else begin
      cap_vld_q <= cap_vld_d;
      strap_q   <= strap_d;
    end
  end

  assign cap_vld_o = cap_vld_q;
  assign strap_o   = strap_q;

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_q |=> (cap_vld_q && $stable(strap_q))); // R1
endmodule

// File: rtl/bseq_rec_asm.sv
module bseq_rec_asm #(
  parameter int CFG_AW = 16,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              commit_i,
  input  logic [7:0]        din_i,
  output logic [15:0]       sig_word_o,
  output logic [CFG_AW-1:0] addr_word_o,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [CFG_DW-1:0] cfg_wdata_o
);
  localparam int REC_W = CFG_AW + CFG_DW;
  localparam int HIST_W = REC_W - 8;

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [REC_W-1:0]  full;
  logic              we_q, we_d;
  logic [CFG_AW-1:0] addr_q, addr_d;
  logic [CFG_DW-1:0] data_q, data_d;

  assign full = {hist_q, din_i};

  always_comb begin
    hist_d = hist_q;
    we_d   = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (push_i) hist_d = full[HIST_W-1:0];
    if (commit_i) begin
      we_d   = 1'b1;
      addr_d = full[REC_W-1 -: CFG_AW];
      data_d = full[CFG_DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      hist_q <= hist_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign sig_word_o  = full[15:0];
  assign addr_word_o = full[CFG_AW-1:0];
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = addr_q;
  assign cfg_wdata_o = data_q;

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q); // R6
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import boot_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [15:0] PREAMBLE  = 16'hC3A5,
  parameter int         ROM_ABYTES = 2,
  parameter int         CFG_AW     = 16,
  parameter int         CFG_DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_vld_i,
  input  logic              strap_i,
  input  logic              i2c_done_i,
  input  logic              i2c_nack_i,
  input  logic [15:0]       sig_word_i,
  input  logic [CFG_AW-1:0] addr_word_i,
  output logic              cmd_valid_o,
  output i2c_op_e           cmd_op_o,
  output logic [7:0]        cmd_wbyte_o,
  output logic              cmd_rd_nack_o,
  output logic              push_o,
  output logic              commit_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int ADDR_BYTES = CFG_AW / 8;
  localparam int REC_BYTES  = (CFG_AW + CFG_DW) / 8;
  localparam int MAXC       = (REC_BYTES > ROM_ABYTES) ? REC_BYTES : ROM_ABYTES;
  localparam int CNT_W      = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] IDX_REC_END  = CNT_W'(REC_BYTES - 1);
  localparam logic [CNT_W-1:0] IDX_ADDR_END = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] IDX_ROMA_END = CNT_W'(ROM_ABYTES - 1);
  localparam logic [CNT_W-1:0] IDX_SIG_END  = CNT_W'(1);

  typedef enum logic [3:0] {
    ST_BOOT, ST_START_W, ST_DEV_W, ST_ROMA, ST_START_R,
    ST_DEV_R, ST_READ, ST_LAST, ST_STOP, ST_FIN
  } st_e;

  st_e              state_q, state_d;
  logic             busy_q, busy_d;
  logic             err_q, err_d;
  logic             sig_q, sig_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             answered;

  assign answered = busy_q && i2c_done_i;

  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    err_d   = err_q;
    sig_d   = sig_q;
    idx_d   = idx_q;
    if (state_q == ST_BOOT) begin
      if (cap_vld_i) state_d = strap_i ? ST_START_W : ST_FIN;
    end else if (state_q != ST_FIN) begin
      if (!busy_q) begin
        busy_d = 1'b1;
      end else if (i2c_done_i) begin
        busy_d = 1'b0;
        case (state_q)
          ST_START_W: state_d = ST_DEV_W;
          ST_DEV_W: begin
            if (i2c_nack_i) begin
              err_d = 1'b1; state_d = ST_STOP;
            end else begin
              state_d = ST_ROMA; idx_d = '0;
            end
          end
          ST_ROMA: begin
            if (i2c_nack_i) begin
              err_d = 1'b1; state_d = ST_STOP;
            end else if (idx_q == IDX_ROMA_END) begin
              state_d = ST_START_R;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          ST_START_R: state_d = ST_DEV_R;
          ST_DEV_R: begin
            if (i2c_nack_i) begin
              err_d = 1'b1; state_d = ST_STOP;
            end else begin
              state_d = ST_READ; idx_d = '0; sig_d = 1'b1;
            end
          end
          ST_READ: begin
            if (sig_q) begin
              if (idx_q == IDX_SIG_END) begin
                sig_d = 1'b0;
                idx_d = '0;
                if (sig_word_i != PREAMBLE) begin
                  err_d = 1'b1; state_d = ST_LAST;
                end
              end else begin
                idx_d = idx_q + 1'b1;
              end
            end else if (idx_q == IDX_ADDR_END && addr_word_i == '1) begin
              state_d = ST_LAST;
            end else if (idx_q == IDX_REC_END) begin
              idx_d = '0;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          ST_LAST: state_d = ST_STOP;
          ST_STOP: state_d = ST_FIN;
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      sig_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      sig_q   <= sig_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    cmd_op_o    = OP_READ;
    cmd_wbyte_o = 8'h00;
    case (state_q)
      ST_START_W, ST_START_R: cmd_op_o = OP_START;
      ST_STOP:                cmd_op_o = OP_STOP;
      ST_DEV_W: begin cmd_op_o = OP_WRITE; cmd_wbyte_o = {DEV_ADDR, 1'b0}; end
      ST_DEV_R: begin cmd_op_o = OP_WRITE; cmd_wbyte_o = {DEV_ADDR, 1'b1}; end
      ST_ROMA:                cmd_op_o = OP_WRITE;
      default:                cmd_op_o = OP_READ;
    endcase
  end

  assign cmd_valid_o   = !busy_q && state_q != ST_BOOT && state_q != ST_FIN;
  assign cmd_rd_nack_o = (state_q == ST_LAST);
  assign push_o        = answered && state_q == ST_READ;
  assign commit_o      = push_o && !sig_q && idx_q == IDX_REC_END;
  assign done_o        = (state_q == ST_FIN);
  assign err_o         = err_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o); // R10
  AST_FIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R9
  AST_WAIT_FOR_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !i2c_done_i) |=> (state_q == $past(state_q))); // R10
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_seq_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR   = 7'h50,
  parameter logic [15:0] PREAMBLE   = 16'hC3A5,
  parameter int          ROM_ABYTES = 2,
  parameter int          CFG_AW     = 16,
  parameter int          CFG_DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap,
  output logic              i2c_cmd_valid,
  output logic [1:0]        i2c_cmd,
  output logic [7:0]        i2c_wbyte,
  output logic              i2c_rd_nack,
  input  logic              i2c_done,
  input  logic              i2c_nack,
  input  logic [7:0]        i2c_rbyte,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_DW-1:0] cfg_wdata,
  output logic              core_hold,
  output logic              seq_done,
  output logic              seq_err
);
  logic              cap_vld, strap_q;
  logic              push, commit, done;
  logic [15:0]       sig_word;
  logic [CFG_AW-1:0] addr_word;
  i2c_op_e           op;

  bseq_strap_latch u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (boot_strap),
    .cap_vld_o (cap_vld),
    .strap_o   (strap_q)
  );

  bseq_rec_asm #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .commit_i    (commit),
    .din_i       (i2c_rbyte),
    .sig_word_o  (sig_word),
    .addr_word_o (addr_word),
    .cfg_we_o    (cfg_we),
    .cfg_addr_o  (cfg_addr),
    .cfg_wdata_o (cfg_wdata)
  );

  bseq_ctrl #(
    .DEV_ADDR(DEV_ADDR), .PREAMBLE(PREAMBLE), .ROM_ABYTES(ROM_ABYTES),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_vld_i     (cap_vld),
    .strap_i       (strap_q),
    .i2c_done_i    (i2c_done),
    .i2c_nack_i    (i2c_nack),
    .sig_word_i    (sig_word),
    .addr_word_i   (addr_word),
    .cmd_valid_o   (i2c_cmd_valid),
    .cmd_op_o      (op),
    .cmd_wbyte_o   (i2c_wbyte),
    .cmd_rd_nack_o (i2c_rd_nack),
    .push_o        (push),
    .commit_o      (commit),
    .done_o        (done),
    .err_o         (seq_err)
  );

  assign i2c_cmd   = op;
  assign seq_done  = done;
  assign core_hold = !done;

  AST_CFG_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> core_hold); // R3
  AST_NO_CMD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (!i2c_cmd_valid && !cfg_we)); // R11
endmodule

// File: tb/tb_boot_sequencer.sv
module tb_boot_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0]  DEV = 7'h50;
  localparam logic [15:0] SIG = 16'hC3A5;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  logic clk = 1'b0;
  logic rst_n, boot_strap;
  logic i2c_cmd_valid, i2c_rd_nack, i2c_done, i2c_nack;
  logic [1:0] i2c_cmd;
  logic [7:0] i2c_wbyte, i2c_rbyte;
  logic cfg_we, core_hold, seq_done, seq_err;
  logic [15:0] cfg_addr;
  logic [31:0] cfg_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sequencer dut (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
    .i2c_cmd_valid(i2c_cmd_valid), .i2c_cmd(i2c_cmd), .i2c_wbyte(i2c_wbyte),
    .i2c_rd_nack(i2c_rd_nack), .i2c_done(i2c_done), .i2c_nack(i2c_nack),
    .i2c_rbyte(i2c_rbyte), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .core_hold(core_hold), .seq_done(seq_done),
    .seq_err(seq_err)
  );

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] rom [0:255];
  int nack_at;

  // observed activity, written only by the engine process
  int act_n, act_w, wr_n, rp, hold_viol, post_viol, dly;
  logic [1:0] act_op [0:511];
  logic [7:0] act_b  [0:511];
  logic       act_nk [0:511];
  logic [15:0] act_wa [0:63];
  logic [31:0] act_wd [0:63];
  logic pend;
  logic [1:0] pop;

  // expected activity
  int exp_n, exp_w;
  logic exp_err;
  logic [1:0] exp_op [0:511];
  logic [7:0] exp_b  [0:511];
  logic       exp_nk [0:511];
  logic [15:0] exp_wa [0:63];
  logic [31:0] exp_wd [0:63];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // I2C engine model and activity monitor
  initial begin
    i2c_done = 1'b0; i2c_nack = 1'b0; i2c_rbyte = 8'h00;
    pend = 1'b0; pop = 2'd0; dly = 0;
    act_n = 0; act_w = 0; wr_n = 0; rp = 0; hold_viol = 0; post_viol = 0;
    forever begin
      @(negedge clk);
      i2c_done = 1'b0;
      i2c_nack = 1'b0;
      if (!rst_n) begin
        pend = 1'b0; act_n = 0; act_w = 0; wr_n = 0; rp = 0;
        hold_viol = 0; post_viol = 0;
        if (!core_hold || seq_done || i2c_cmd_valid || cfg_we) hold_viol++;
      end else begin
        if (!seq_done && !core_hold) hold_viol++;
        if (seq_done && core_hold) hold_viol++;
        if (seq_done && (i2c_cmd_valid || cfg_we)) post_viol++;
        if (pend) begin
          if (dly == 0) begin
            pend = 1'b0;
            i2c_done = 1'b1;
            case (pop)
              C_START: rp = 0;
              C_WRITE: begin i2c_nack = (wr_n == nack_at); wr_n++; end
              C_READ:  begin i2c_rbyte = rom[rp[7:0]]; rp++; end
              default: ;
            endcase
          end else dly--;
        end
        if (i2c_cmd_valid) begin
          if (pend || i2c_done) post_viol++;
          if (act_n < 512) begin
            act_op[act_n] = i2c_cmd;
            act_b[act_n]  = (i2c_cmd == C_WRITE) ? i2c_wbyte : 8'h00;
            act_nk[act_n] = (i2c_cmd == C_READ) ? i2c_rd_nack : 1'b0;
          end
          act_n++;
          pend = 1'b1; pop = i2c_cmd; dly = int'($urandom % 3);
        end
        if (cfg_we) begin
          if (act_w < 64) begin act_wa[act_w] = cfg_addr; act_wd[act_w] = cfg_wdata; end
          act_w++;
        end
      end
    end
  end

  function automatic void add(input logic [1:0] op, input logic [7:0] b, input logic nk);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_nk[exp_n] = nk; exp_n++;
  endfunction

  function automatic void build_exp(input bit en, input int nk);
    int p;
    logic [15:0] a;
    exp_n = 0; exp_w = 0; exp_err = 1'b0;
    if (!en) return;
    add(C_START, 8'h00, 1'b0);
    add(C_WRITE, {DEV, 1'b0}, 1'b0);
    if (nk == 0) begin add(C_STOP, 8'h00, 1'b0); exp_err = 1'b1; return; end
    add(C_WRITE, 8'h00, 1'b0);
    if (nk == 1) begin add(C_STOP, 8'h00, 1'b0); exp_err = 1'b1; return; end
    add(C_WRITE, 8'h00, 1'b0);
    if (nk == 2) begin add(C_STOP, 8'h00, 1'b0); exp_err = 1'b1; return; end
    add(C_START, 8'h00, 1'b0);
    add(C_WRITE, {DEV, 1'b1}, 1'b0);
    if (nk == 3) begin add(C_STOP, 8'h00, 1'b0); exp_err = 1'b1; return; end
    add(C_READ, 8'h00, 1'b0); add(C_READ, 8'h00, 1'b0);
    if ({rom[0], rom[1]} != SIG) begin
      exp_err = 1'b1;
      add(C_READ, 8'h00, 1'b1); add(C_STOP, 8'h00, 1'b0);
      return;
    end
    p = 2;
    while (p < 250) begin
      a = {rom[p], rom[p+1]};
      add(C_READ, 8'h00, 1'b0); add(C_READ, 8'h00, 1'b0);
      if (a == 16'hFFFF) break;
      for (int k = 0; k < 4; k++) add(C_READ, 8'h00, 1'b0);
      exp_wa[exp_w] = a;
      exp_wd[exp_w] = {rom[p+2], rom[p+3], rom[p+4], rom[p+5]};
      exp_w++;
      p += 6;
    end
    add(C_READ, 8'h00, 1'b1); add(C_STOP, 8'h00, 1'b0);
  endfunction

  function automatic void put_rec(input int i, input logic [15:0] a, input logic [31:0] d);
    int p = 2 + 6 * i;
    {rom[p], rom[p+1]} = a;
    {rom[p+2], rom[p+3], rom[p+4], rom[p+5]} = d;
  endfunction

  function automatic void new_rom(input logic [15:0] sig);
    for (int i = 0; i < 256; i++) rom[i] = 8'(i * 37 + 5);
    {rom[0], rom[1]} = sig;
  endfunction

  task automatic run_case(input string name, input bit s0, input bit s1, input int nk);
    int lim;
    bit same;
    int first;
    nack_at = nk;
    build_exp(s0, nk);
    rst_n = 1'b0; boot_strap = s0;
    repeat (3) @(negedge clk);
    chk(core_hold && !seq_done && !i2c_cmd_valid && !cfg_we, "R3", {name, " reset state"},
        {core_hold, seq_done, i2c_cmd_valid, cfg_we}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!seq_done && core_hold, "R1", {name, " held after capture edge"},
        {seq_done, core_hold}, 2'b01);
    boot_strap = s1;
    @(negedge clk);
    if (!s0)
      chk(seq_done && !core_hold && !seq_err, "R2", {name, " immediate release"},
          {seq_done, core_hold, seq_err}, 3'b100);
    lim = 0;
    while (!seq_done && lim < 5000) begin @(negedge clk); lim++; end
    chk(seq_done, "R3", {name, " finished"}, lim, 0);
    repeat (10) @(negedge clk);
    chk(seq_done && !core_hold, "R3", {name, " done sticky"}, {seq_done, core_hold}, 2'b10);
    chk(seq_err == exp_err, exp_err ? (nk >= 0 ? "R9" : "R5") : "R7", {name, " error flag"},
        seq_err, exp_err);
    chk(hold_viol == 0, "R3", {name, " hold tracks done"}, hold_viol, 0);
    chk(post_viol == 0, "R11", {name, " quiet after done, R10 one outstanding"}, post_viol, 0);
    chk(act_n == exp_n, s0 ? "R4" : "R2", {name, " command count"}, act_n, exp_n);
    same = 1'b1; first = -1;
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (act_op[i] != exp_op[i] || act_b[i] != exp_b[i] || act_nk[i] != exp_nk[i]) begin
        if (same) first = i;
        same = 1'b0;
      end
    if (first >= 0)
      chk(1'b0, "R8", {name, " command log"}, {act_op[first], act_b[first], act_nk[first]},
          {exp_op[first], exp_b[first], exp_nk[first]});
    else
      chk(1'b1, "R4", {name, " command log"}, 0, 0);
    chk(act_w == exp_w, "R6", {name, " write count"}, act_w, exp_w);
    for (int i = 0; i < exp_w && i < act_w; i++)
      chk(act_wa[i] == exp_wa[i] && act_wd[i] == exp_wd[i], "R6", {name, " write content"},
          {act_wa[i], act_wd[i]}, {exp_wa[i], exp_wd[i]});
  endtask

  initial begin
    logic [15:0] a;
    int n;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; boot_strap = 1'b0; nack_at = -1;
    new_rom(SIG);
    put_rec(0, 16'hFFFF, 32'h0);

    run_case("strap_off", 1'b0, 1'b0, -1);
    run_case("strap_off_late_on", 1'b0, 1'b1, -1);            // R1
    new_rom(SIG);
    put_rec(0, 16'h0010, 32'h11223344);
    put_rec(1, 16'h8000, 32'hDEADBEEF);
    put_rec(2, 16'hFFFF, 32'h0);
    run_case("strap_on_late_off", 1'b1, 1'b0, -1);            // R1 R6
    new_rom(SIG);
    put_rec(0, 16'hFFFF, 32'h0);
    run_case("empty_list", 1'b1, 1'b1, -1);                   // R7 R8
    new_rom(SIG);
    put_rec(0, 16'hFF12, 32'hA5A5_0F0F);
    put_rec(1, 16'h12FF, 32'h0000_0001);
    put_rec(2, 16'hFFFF, 32'h0);
    run_case("ff_high_byte", 1'b1, 1'b1, -1);                 // R7
    new_rom(16'h00A5);
    put_rec(0, 16'h0004, 32'h1);
    put_rec(1, 16'hFFFF, 32'h0);
    run_case("bad_sig_hi", 1'b1, 1'b1, -1);                   // R5
    new_rom(16'hC300);
    put_rec(0, 16'h0004, 32'h1);
    put_rec(1, 16'hFFFF, 32'h0);
    run_case("bad_sig_lo", 1'b1, 1'b1, -1);                   // R5
    run_case("nack_dev_w", 1'b1, 1'b1, 0);                    // R9
    run_case("nack_rom_addr", 1'b1, 1'b1, 1);                 // R9
    run_case("nack_dev_r", 1'b1, 1'b1, 3);                    // R9

    for (int t = 0; t < 8; t++) begin
      new_rom(SIG);
      n = int'($urandom % 6);
      for (int i = 0; i < n; i++) begin
        a = 16'($urandom);
        if ($urandom % 4 == 0) a[15:8] = 8'hFF;
        if (a == 16'hFFFF) a = 16'h0000;
        put_rec(i, a, $urandom);
      end
      put_rec(n, 16'hFFFF, $urandom);
      run_case("random", 1'b1, 1'($urandom), -1);             // R4 R6 R8
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule